// File: doc/BRIEF.md
# Keyed Unlock and Error Status Controller

This block watches over a protected register-access unit. A protected channel must be unlocked with a key before it can be used, and each unlock covers exactly one access. Software reaches the block through a simple register-bus slave. Over that bus it sets an enable bit and a setup-mode bit, fills a table of remap address entries and writes unlock requests. The block also follows a master-side completion handshake in which each transfer ends with a done pulse that may carry an error.

A 32-bit status word is driven straight from flip-flops. It holds live flags for enabled, setup and busy, and five sticky error flags. The error flags record:
- a remap address outside the allowed window,
- a master bus error,
- an unlock refused because errors are pending,
- a wrong key,
- a read of the unlock register.

Each sticky flag stays set until software writes a one to the matching bit of a write-one-to-clear register. An unlock is refused while any error flag is set, so software has to clear the record before it can unlock a channel again.

Top module: `keyed_guard`

## Requirements
- R1: After synchronous reset, `status_o` is 0x00000000, `bus_rdata` is 0 and `chan_grant` is 0.
- R2: The register word offsets are: control 0x00, unlock 0x04, clear 0x08, status 0x0C (read only), and remap entries from 0x10 upward, one 32-bit entry every 4 bytes. Control bit 0 is enable and bit 1 is setup mode. They appear in `status_o` bits 0 and 1 in the cycle after the write.
- R3: `status_o` bit 2 (busy) is set in the cycle after a granted access. It clears after the `mst_done` pulse that leaves no master transfer outstanding, and stays set while other transfers remain.
- R4: In setup mode, a remap write whose upper 16 bits are 0xFFFC to 0xFFFF is stored. Any other value is not stored and sets sticky bit 8 (address error).
- R5: A remap write outside setup mode is ignored. It stores nothing and leaves bit 8 unchanged.
- R6: `mst_done` together with `mst_err` sets sticky bit 9 (master bus error).
- R7: A write to the unlock register while any of status bits 8 to 12 is set unlocks nothing and sets sticky bit 10 (unlock refused).
- R8: An unlock write with no error pending and a key (write data bits 31:24) other than 0xA5 sets sticky bit 11 (bad key) and unlocks nothing.
- R9: An unlock write with key 0xA5 and no error pending unlocks the channel given in write data bits 1:0. `chan_start` is granted (`chan_grant` high in the next cycle) only when the unit is enabled and the selected channel is unlocked. A grant consumes the unlock.
- R10: Any read of the unlock register sets sticky bit 12 (unlock read).
- R11: A write to the clear register clears each of status bits 8 to 12 whose write data bit is one. If a flag's set event and its clear arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read |
| chan_start | input | 1 | Request to start an access on a protected channel |
| chan_sel | input | 2 | Channel number for `chan_start` |
| chan_grant | output | 1 | Pulse: the access was accepted |
| mst_done | input | 1 | Master transfer completed |
| mst_err | input | 1 | Completing transfer returned a bus error |
| status_o | output | 32 | Status word |

## Verification
Every result of this block is due exactly one clock edge after its stimulus:
- the status bits,
- the grant pulse,
- read data, including remap readback.

The bench therefore applies each stimulus at a falling edge, lets one rising edge pass and compares at the following falling edge. The vector table steps through control, remap, unlock, clear and completion operations, with the expected status word for each step. Directed cases then check:
- the multi-transfer busy window, where busy must persist after the first of two completions;
- a same-cycle set and clear;
- grants refused for the wrong channel or while the unit is disabled;
- remap readback that shows ignored and illegal writes left the table untouched.

// File: rtl/keyed_guard_pkg.sv
package keyed_guard_pkg;
  localparam int REG_AW = 8;
  localparam int DW     = 32;
  localparam logic [5:0] W_CTRL   = 6'd0;
  localparam logic [5:0] W_UNLOCK = 6'd1;
  localparam logic [5:0] W_CLEAR  = 6'd2;
  localparam logic [5:0] W_STATUS = 6'd3;
  localparam logic [5:0] W_REMAP0 = 6'd4;
  localparam int ERR_LSB = 8;
  localparam int NERR    = 5;
  // sticky flag index inside the error vector
  localparam int E_ADDR   = 0;
  localparam int E_MBUS   = 1;
  localparam int E_REFUSE = 2;
  localparam int E_BADKEY = 3;
  localparam int E_UREAD  = 4;
  localparam logic [15:0] WIN_LOW = 16'hFFFC;
endpackage

// File: rtl/kg_remap_table.sv
module kg_remap_table #(
  parameter int N  = 4,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          wr_i,
  input  logic          setup_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rdata_o,
  output logic          bad_o
);
  import keyed_guard_pkg::*;

  logic [DW-1:0] mem [N];
  logic          legal;

  assign legal = (wdata_i[DW-1:DW-16] >= WIN_LOW);
  assign bad_o = wr_i && setup_i && !legal;

  always_ff @(posedge clk) begin
    if (wr_i && setup_i && legal) mem[wr_idx_i] <= wdata_i;
    if (rd_i) rdata_o <= mem[rd_idx_i];
  end

  // R5
  idle_bad_chk: assert property (@(posedge clk) !setup_i |-> !bad_o);
endmodule

// File: rtl/kg_unlock.sv
module kg_unlock #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter logic [7:0] KEY = 8'hA5,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            err_any_i,
  input  logic            use_i,
  input  logic [CH_W-1:0] use_ch_i,
  output logic [NCH-1:0]  mask_o,
  output logic            refuse_o,
  output logic            badkey_o
);
  logic            key_ok, open_ev;
  logic [CH_W-1:0] ch;
  logic [NCH-1:0]  nxt;
  logic            unused_bits;

  assign ch          = wdata_i[CH_W-1:0];
  assign key_ok      = (wdata_i[DW-1:DW-8] == KEY);
  assign refuse_o    = wr_i && err_any_i;
  assign badkey_o    = wr_i && !err_any_i && !key_ok;
  assign open_ev     = wr_i && !err_any_i && key_ok;
  assign unused_bits = ^wdata_i[DW-9:CH_W];

  always_comb begin
    nxt = mask_o;
    if (use_i) nxt[use_ch_i] = 1'b0;
    if (open_ev) nxt[ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '0;
    else     mask_o <= nxt;
  end

  // R7
  refuse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (refuse_o && !use_i) |=> (mask_o == $past(mask_o)));
endmodule

// File: rtl/kg_activity.sv
module kg_activity #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o,
  output logic full_o
);
  logic [PEND_W-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (start_i) cnt_nxt = cnt_nxt + 1'b1;
    if (done_i && cnt != '0) cnt_nxt = cnt_nxt - 1'b1;
  end

  assign full_o = &cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      busy_o <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      busy_o <= (cnt_nxt != '0);
    end
  end

  // R3
  idle_return_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(done_i));
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);
endmodule

// File: rtl/keyed_guard.sv
module keyed_guard #(
  parameter int NCH    = 4,
  parameter int NREMAP = 4,
  parameter int PEND_W = 3,
  parameter logic [7:0] KEY = 8'hA5,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RIW  = (NREMAP > 1) ? $clog2(NREMAP) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            chan_start,
  input  logic [CH_W-1:0] chan_sel,
  output logic            chan_grant,
  input  logic            mst_done,
  input  logic            mst_err,
  output logic [31:0]     status_o
);
  import keyed_guard_pkg::*;

  logic            wr, rd, en, setup, busy, full, grant;
  logic [5:0]      word, rel;
  logic            remap_hit, addr_ev, refuse_ev, badkey_ev;
  logic [RIW-1:0]  ridx;
  logic [NCH-1:0]  mask;
  logic [NERR-1:0] err, err_set, err_clr;
  logic [31:0]     tbl_q, reg_q;
  logic            tbl_sel;
  logic            unused_addr;

  assign wr          = bus_sel && bus_wr;
  assign rd          = bus_sel && !bus_wr;
  assign word        = bus_addr[7:2];
  assign unused_addr = ^bus_addr[1:0];
  assign rel         = word - W_REMAP0;
  assign ridx        = rel[RIW-1:0];
  assign remap_hit   = (word >= W_REMAP0) && ({26'd0, rel} < NREMAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      setup <= 1'b0;
    end else if (wr && word == W_CTRL) begin
      en    <= bus_wdata[0];
      setup <= bus_wdata[1];
    end
  end

  kg_remap_table #(.N(NREMAP), .DW(32)) i_table (
    .clk(clk), .wr_i(wr && remap_hit), .setup_i(setup), .wr_idx_i(ridx),
    .wdata_i(bus_wdata), .rd_i(rd && remap_hit), .rd_idx_i(ridx),
    .rdata_o(tbl_q), .bad_o(addr_ev));

  kg_unlock #(.NCH(NCH), .DW(32), .KEY(KEY)) i_unlock (
    .clk(clk), .rst(rst), .wr_i(wr && word == W_UNLOCK), .wdata_i(bus_wdata),
    .err_any_i(|err), .use_i(grant), .use_ch_i(chan_sel),
    .mask_o(mask), .refuse_o(refuse_ev), .badkey_o(badkey_ev));

  assign grant = chan_start && en && mask[chan_sel] && !full;

  kg_activity #(.PEND_W(PEND_W)) i_activity (
    .clk(clk), .rst(rst), .start_i(grant), .done_i(mst_done),
    .busy_o(busy), .full_o(full));

  always_comb begin
    err_set           = '0;
    err_set[E_ADDR]   = addr_ev;
    err_set[E_MBUS]   = mst_done && mst_err;
    err_set[E_REFUSE] = refuse_ev;
    err_set[E_BADKEY] = badkey_ev;
    err_set[E_UREAD]  = rd && word == W_UNLOCK;
    err_clr = (wr && word == W_CLEAR) ? bus_wdata[ERR_LSB +: NERR] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err        <= '0;
      chan_grant <= 1'b0;
    end else begin
      err        <= (err & ~err_clr) | err_set;
      chan_grant <= grant;
    end
  end

  assign status_o = {{(32-ERR_LSB-NERR){1'b0}}, err, {(ERR_LSB-3){1'b0}}, busy, setup, en};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= '0;
      tbl_sel <= 1'b0;
    end else if (rd) begin
      tbl_sel <= remap_hit;
      case (word)
        W_CTRL:   reg_q <= {30'd0, setup, en};
        W_UNLOCK: reg_q <= 32'(mask);
        W_STATUS: reg_q <= status_o;
        default:  reg_q <= '0;
      endcase
    end
  end

  assign bus_rdata = tbl_sel ? tbl_q : reg_q;

  // R7
  refuse_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && word == W_UNLOCK && |err) |=> err[E_REFUSE]);
  // R8
  badkey_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && word == W_UNLOCK && !(|err) && bus_wdata[31:24] != KEY) |=> err[E_BADKEY]);
  // R6
  mbus_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mst_done && mst_err) |=> err[E_MBUS]);
  // R11
  sticky_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (err[E_ADDR] && !(wr && word == W_CLEAR && bus_wdata[ERR_LSB + E_ADDR])) |=> err[E_ADDR]);
  // R5
  remap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && remap_hit && !setup && !err[E_ADDR]) |=> !err[E_ADDR]);
  // R9
  grant_en_chk: assert property (@(posedge clk) disable iff (rst)
    chan_grant |-> $past(en));
endmodule

// File: tb/test_keyed_guard.sv
`timescale 1ns/100ps
module test_keyed_guard;
  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_sel = 0, bus_wr = 0, chan_start = 0, mst_done = 0, mst_err = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [1:0]  chan_sel = 0;
  logic [31:0] bus_rdata, status_o;
  logic        chan_grant;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  keyed_guard i_keyed_guard (.*);

  // vector: op(4) addr(8) data(32) expected status(32)
  // op 0 write, 1 read, 2 start (channel = data[1:0]), 3 done (err = data[0])
  localparam logic [75:0] VEC [17] = '{
    {4'd0, 8'h00, 32'h0000_0003, 32'h0000_0003},  // R2 enable + setup
    {4'd0, 8'h10, 32'hFFFC_1234, 32'h0000_0003},  // R4 legal entry
    {4'd0, 8'h14, 32'h1234_0000, 32'h0000_0103},  // R4 illegal entry
    {4'd0, 8'h04, 32'hA500_0001, 32'h0000_0503},  // R7 refused
    {4'd0, 8'h08, 32'h0000_0500, 32'h0000_0003},  // R11 clear
    {4'd0, 8'h04, 32'h3C00_0001, 32'h0000_0803},  // R8 bad key
    {4'd0, 8'h08, 32'h0000_0800, 32'h0000_0003},  // R11
    {4'd0, 8'h04, 32'hA500_0001, 32'h0000_0003},  // R9 unlock ch1
    {4'd2, 8'h00, 32'h0000_0001, 32'h0000_0007},  // R3 busy
    {4'd3, 8'h00, 32'h0000_0001, 32'h0000_0203},  // R6 bus error, idle
    {4'd0, 8'h08, 32'h0000_0200, 32'h0000_0003},  // R11
    {4'd2, 8'h00, 32'h0000_0001, 32'h0000_0003},  // R9 unlock consumed
    {4'd1, 8'h04, 32'h0000_0000, 32'h0000_1003},  // R10 unlock read
    {4'd0, 8'h08, 32'h0000_1000, 32'h0000_0003},  // R11
    {4'd0, 8'h00, 32'h0000_0001, 32'h0000_0001},  // R2 leave setup
    {4'd0, 8'h18, 32'h0000_0000, 32'h0000_0001},  // R5 no address error
    {4'd0, 8'h00, 32'h0000_0000, 32'h0000_0000}   // R2 disable
  };

  task automatic cyc(input bit s, input bit w, input logic [7:0] a, input logic [31:0] d,
                     input bit st, input logic [1:0] ch, input bit dn, input bit er);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    chan_start = st; chan_sel = ch; mst_done = dn; mst_err = er;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; chan_start = 0; mst_done = 0; mst_err = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 status", status_o, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 grant", {31'd0, chan_grant}, 32'h0);

    for (int i = 0; i < 17; i++) begin
      case (VEC[i][75:72])
        4'd0: cyc(1, 1, VEC[i][71:64], VEC[i][63:32], 0, 0, 0, 0);
        4'd1: cyc(1, 0, VEC[i][71:64], 0, 0, 0, 0, 0);
        4'd2: cyc(0, 0, 0, 0, 1, VEC[i][33:32], 0, 0);
        default: cyc(0, 0, 0, 0, 0, 0, 1, VEC[i][32]);
      endcase
      check($sformatf("vector %0d", i), status_o, VEC[i][31:0]);
    end

    // R5: write outside setup leaves the stored entry
    cyc(1, 1, 8'h00, 32'h1, 0, 0, 0, 0);
    cyc(1, 1, 8'h10, 32'hFFFD_0000, 0, 0, 0, 0);
    cyc(1, 0, 8'h10, 0, 0, 0, 0, 0);
    check("R5 remap readback", bus_rdata, 32'hFFFC_1234);
    // R4: illegal write in setup does not overwrite
    cyc(1, 1, 8'h00, 32'h3, 0, 0, 0, 0);
    cyc(1, 1, 8'h18, 32'hFFFF_ABCD, 0, 0, 0, 0);
    cyc(1, 1, 8'h18, 32'h0001_0000, 0, 0, 0, 0);
    check("R4 flag", status_o, 32'h0000_0103);
    cyc(1, 0, 8'h18, 0, 0, 0, 0, 0);
    check("R4 remap readback", bus_rdata, 32'hFFFF_ABCD);
    cyc(1, 1, 8'h08, 32'h0000_1F00, 0, 0, 0, 0);
    cyc(1, 1, 8'h00, 32'h1, 0, 0, 0, 0);
    check("R2 control readback prep", status_o, 32'h1);

    // R9: wrong channel, then right channel
    cyc(1, 1, 8'h04, 32'hA500_0002, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 2'd3, 0, 0);
    check("R9 wrong channel", {31'd0, chan_grant}, 32'h0);
    cyc(0, 0, 0, 0, 1, 2'd2, 0, 0);
    check("R9 grant", {31'd0, chan_grant}, 32'h1);
    // R3: two transfers pending
    cyc(1, 1, 8'h04, 32'hA500_0000, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 2'd0, 0, 0);
    check("R9 second grant", {31'd0, chan_grant}, 32'h1);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    check("R3 still busy", status_o, 32'h5);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    check("R3 idle", status_o, 32'h1);

    // R11: set and clear in the same cycle, set wins
    cyc(1, 1, 8'h04, 32'hA500_0001, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 2'd1, 0, 0);
    cyc(1, 1, 8'h08, 32'h0000_0200, 0, 0, 1, 1);
    check("R11 set wins", status_o, 32'h201);
    cyc(1, 1, 8'h08, 32'h0000_0200, 0, 0, 0, 0);
    check("R11 cleared", status_o, 32'h1);

    // R9: disabled unit refuses a grant
    cyc(1, 1, 8'h04, 32'hA500_0003, 0, 0, 0, 0);
    cyc(1, 1, 8'h00, 32'h0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 2'd3, 0, 0);
    check("R9 disabled", {31'd0, chan_grant}, 32'h0);
    cyc(1, 0, 8'h04, 0, 0, 0, 0, 0);
    check("R9 unlock kept", bus_rdata, 32'h8);
    check("R10 read flag", status_o, 32'h1000);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule